// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD registers. An external prescaler turns a 32,768 Hz reference into a clean one-cycle pulse every hundredth of a second. Each pulse advances the hundredths register. The carries then ripple through seconds, minutes, hours, weekday, date, month, year and a century flag.

The date rolls over at the right end of each month. February is given 29 days whenever the two-digit year is a multiple of four. A host can load any register through an indexed write port and can read any register through an indexed read port. A write takes priority over a tick in the same cycle.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset, the time reads 00:00:00.00, the weekday reads 01, the date reads 01, the month reads 01, the year reads 00 and the century bit is 0.
- R2: Each cycle with `tick` high and `wr_en` low adds one to the hundredths register in packed BCD. Without a tick, no register changes.
- R3: Hundredths wrap from 99 to 00 and carry into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R4: Hours count 00 to 23 and wrap to 00. That wrap advances both the date and the weekday.
- R5: The weekday counts 01 to 07 and wraps to 01.
- R6: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R7: In month 02 the date wraps after 29 when the BCD year is divisible by four (00 included), and after 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and inverts the century bit.
- R9: A write with `wr_en` high loads `wr_data` into the indexed register at the next clock edge. Any tick in that same cycle is discarded, so no other register changes.
- R10: The register index map is 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, and 8 century (bit 0). `rd_data` shows the indexed register without delay. Indices 9 to 15 read 00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per hundredth of a second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Register index to write |
| wr_data | input | 8 | Packed BCD value to write |
| rd_addr | input | 4 | Register index to read |
| rd_data | output | 8 | Contents of the indexed register |

## Verification
The counter is first stepped by a run of plain ticks from reset, which confirms the BCD digit step from 9 to the next ten. It is then preloaded just before each boundary and given one tick.

The boundaries are the end of a 30-day month, the end of a 31-day month, February 28 in years 23, 24 and 00, February 29 in a leap year, and December 31 in years 99 and 41. Together these separate the month-length table, the leap test and the century toggle. A write that coincides with a tick shows that writes win over ticks. A write to an unused index shows that such writes have no effect.

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data
);
  logic [7:0] hs, sec, mn, hr, dow, dt, mo, yr;
  logic       cen;
  logic [7:0] last_day;
  logic       leap;
  logic       c0, c1, c2, c3, c4, c5, c6, c7;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  always_comb begin
    case (mo)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c0 = tick & ~wr_en;
  assign c1 = c0 & (hs == 8'h99);
  assign c2 = c1 & (sec == 8'h59);
  assign c3 = c2 & (mn == 8'h59);
  assign c4 = c3 & (hr == 8'h23);
  assign c5 = c4 & (dt == last_day);
  assign c6 = c5 & (mo == 8'h12);
  assign c7 = c6 & (yr == 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs  <= 8'h00; sec <= 8'h00; mn <= 8'h00; hr <= 8'h00;
      dow <= 8'h01; dt  <= 8'h01; mo <= 8'h01; yr <= 8'h00;
      cen <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: hs  <= wr_data;
        4'd1: sec <= wr_data;
        4'd2: mn  <= wr_data;
        4'd3: hr  <= wr_data;
        4'd4: dow <= wr_data;
        4'd5: dt  <= wr_data;
        4'd6: mo  <= wr_data;
        4'd7: yr  <= wr_data;
        4'd8: cen <= wr_data[0];
        default: ;
      endcase
    end else begin
      if (c0) hs  <= c1 ? 8'h00 : binc(hs);
      if (c1) sec <= c2 ? 8'h00 : binc(sec);
      if (c2) mn  <= c3 ? 8'h00 : binc(mn);
      if (c3) hr  <= c4 ? 8'h00 : binc(hr);
      if (c4) dow <= (dow == 8'h07) ? 8'h01 : binc(dow);
      if (c4) dt  <= c5 ? 8'h01 : binc(dt);
      if (c5) mo  <= c6 ? 8'h01 : binc(mo);
      if (c6) yr  <= c7 ? 8'h00 : binc(yr);
      if (c7) cen <= ~cen;
    end
  end

  always_comb begin
    case (rd_addr)
      4'd0: rd_data = hs;
      4'd1: rd_data = sec;
      4'd2: rd_data = mn;
      4'd3: rd_data = hr;
      4'd4: rd_data = dow;
      4'd5: rd_data = dt;
      4'd6: rd_data = mo;
      4'd7: rd_data = yr;
      4'd8: rd_data = {7'd0, cen};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module bcd_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] hs, sec, mn, hr, dow, dt, mo, yr,
  input logic       cen
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(hs) && $stable(sec) && $stable(dt)));

  p_sec_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && hs == 8'h99 && sec == 8'h41) |=> (hs == 8'h00 && sec == 8'h42));

  p_day_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && hs == 8'h99 && sec == 8'h59 && mn == 8'h59 && hr == 8'h23)
      |=> (hr == 8'h00 && dt != $past(dt) && dow != $past(dow)));

  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && hs == 8'h99 && sec == 8'h59 && mn == 8'h59 && hr == 8'h23 && dow == 8'h07)
      |=> (dow == 8'h01));

  p_century_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && hs == 8'h99 && sec == 8'h59 && mn == 8'h59 && hr == 8'h23 &&
     dt == 8'h31 && mo == 8'h12 && yr == 8'h99) |=> (yr == 8'h00 && cen != $past(cen)));

  p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd3) |=> (hr == $past(wr_data)));

  p_write_blocks_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 4'd0) |=> $stable(hs));
endmodule

bind bcd_calendar_counter bcd_calendar_checker u_chk (.*);

// File: tb/test_bcd_calendar_counter.sv
module test_bcd_calendar_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  bcd_calendar_counter i_bcd_calendar_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string r);
    item_t it;
    it.addr = a; it.exp = e; it.req = r;
    q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      rd_addr = it.addr;
      #1;
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s index %0d actual %h expected %h", it.req, it.addr, rd_data, it.exp);
      end
      popped++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, s, m, hh, w, d, mm, y, input logic c);
    wr(0, h); wr(1, s); wr(2, m); wr(3, hh);
    wr(4, w); wr(5, d); wr(6, mm); wr(7, y); wr(8, {7'd0, c});
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    expect_reg(0, 8'h00, "R1"); expect_reg(3, 8'h00, "R1");
    expect_reg(4, 8'h01, "R1"); expect_reg(5, 8'h01, "R1");
    expect_reg(6, 8'h01, "R1"); expect_reg(7, 8'h00, "R1");
    expect_reg(8, 8'h00, "R1");
    // R2 BCD counting and idle hold
    ticks(37);
    expect_reg(0, 8'h37, "R2");
    repeat (5) @(negedge clk);
    expect_reg(0, 8'h37, "R2");
    // R3 cascade through seconds and minutes
    set_all(8'h99, 8'h59, 8'h59, 8'h22, 8'h03, 8'h10, 8'h05, 8'h30, 1'b0);
    ticks(1);
    expect_reg(0, 8'h00, "R3"); expect_reg(1, 8'h00, "R3");
    expect_reg(2, 8'h00, "R3"); expect_reg(3, 8'h23, "R3");
    // R4 R5 day rollover and weekday wrap
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h30, 1'b0);
    ticks(1);
    expect_reg(3, 8'h00, "R4"); expect_reg(5, 8'h16, "R4");
    expect_reg(4, 8'h01, "R5");
    // R6 thirty-day month end
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h30, 1'b0);
    ticks(1);
    expect_reg(5, 8'h01, "R6"); expect_reg(6, 8'h05, "R6");
    expect_reg(4, 8'h03, "R5");
    // R6 day 30 in a 31-day month does not wrap
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h30, 1'b0);
    ticks(1);
    expect_reg(5, 8'h31, "R6"); expect_reg(6, 8'h01, "R6");
    ticks(8640000 / 86400 * 0 + 1); // only hundredths step, no day change
    expect_reg(5, 8'h31, "R6");
    // R6 31-day month end
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h30, 1'b0);
    ticks(1);
    expect_reg(5, 8'h01, "R6"); expect_reg(6, 8'h02, "R6");
    // R7 non-leap February 28
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 1'b0);
    ticks(1);
    expect_reg(5, 8'h01, "R7"); expect_reg(6, 8'h03, "R7");
    // R7 leap February 28 -> 29 -> March 01
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 1'b0);
    ticks(1);
    expect_reg(5, 8'h29, "R7"); expect_reg(6, 8'h02, "R7");
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24, 1'b0);
    ticks(1);
    expect_reg(5, 8'h01, "R7"); expect_reg(6, 8'h03, "R7");
    // R7 year 00 is leap
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 1'b0);
    ticks(1);
    expect_reg(5, 8'h29, "R7");
    // R8 year end with century toggle
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 1'b0);
    ticks(1);
    expect_reg(5, 8'h01, "R8"); expect_reg(6, 8'h01, "R8");
    expect_reg(7, 8'h00, "R8"); expect_reg(8, 8'h01, "R8");
    // R8 ordinary year end keeps century
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h41, 1'b1);
    ticks(1);
    expect_reg(7, 8'h42, "R8"); expect_reg(8, 8'h01, "R8");
    // R9 write wins over a coincident tick
    wr(0, 8'h50);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h33;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg(0, 8'h50, "R9"); expect_reg(2, 8'h33, "R9");
    // R10 unused index: reads zero, write has no effect
    wr(4'd12, 8'h5A);
    expect_reg(4'd12, 8'h00, "R10");
    expect_reg(0, 8'h50, "R10"); expect_reg(2, 8'h33, "R10");
    expect_reg(7, 8'h42, "R10");
    done = 1'b1;
    finish_run();
  end
endmodule